// File: doc/BRIEF.md
# Private Cache Token Coherence Agent

This block is the coherence agent that sits beside one core's private cache in a directory protocol where correctness rests on token counting. Every line carries a fixed total of tokens, equal to the number of cores. A cache may read a line while it holds at least one token and may write it only while it holds all of them. The agent keeps a token count, an owner flag and a write-permission flag per line, in a small table indexed directly by line number. That table stands in for the cache arrays.

The agent has three jobs. On the network side it answers reconstruction broadcasts and requests forwarded by the directory. It stays silent whenever it holds no tokens, so the directory learns sharing from token reports instead of from acknowledgements. For its own core it turns misses into requests to the home directory, adds up the tokens that arrive, and declares a miss finished from token arithmetic alone. For evictions it returns the line's tokens home, together with the data when it holds ownership. Token messages that match no open miss are sent back home rather than lost.

The core side is a valid/ready operation port with a one-cycle done pulse. The network side has one valid/ready input message port and one valid/ready output message port. An event that needs two messages emits them back to back, in a fixed order.

Top module: `tca_agent`

## Requirements
- R1: After reset no output message is valid, both ready outputs are high, and every line holds zero tokens, so a core read of any line misses.
- R2: A snoop (input type 0 read reconstruction, 1 write reconstruction, 2 forwarded read, 3 forwarded write) for a line holding zero tokens produces no output message and leaves the line unchanged.
- R3: A read snoop (type 0 or 2) at the owner emits two messages in order. The first is data (output type 2) to the requestor carrying one token. The second is a report (output type 4) to home carrying the remaining count and an owner flag. When the owner held a single token, ownership passes with the data and the report carries zero tokens and owner 0.
- R4: A read snoop at a non-owner holder emits only a report (type 4) to home with its full count and owner 0, and the holder keeps its tokens.
- R5: A write snoop (type 1 or 3) at any holder sends all its tokens straight to the requestor, as data (type 2, owner 1) when it is the owner and as tokens (type 3) otherwise. It sends nothing to home and leaves the line with zero tokens.
- R6: A core read (op 0) on a zero-token line sends a read request (type 0) to home and holds the core port busy. The miss ends only on a token message that carries data (input type 4) and leaves at least one token. It then sends Unblock (type 5) to home with the new count and owner flag, and pulses done.
- R7: A core write (op 1) without all tokens sends a write request (type 1) to home. Token messages (input types 4 and 5) add to the count. The miss ends when the count reaches the total, with Unblock (type 5) and a done pulse.
- R8: A core write on a line holding all tokens, or a core read on a line holding at least one token, pulses done the next cycle without any message.
- R9: A core eviction (op 2) sends its tokens to home as put-data (type 6, owner 1) when the line is owned and as put-tokens (type 7) otherwise, then clears the line. An eviction of a zero-token line sends nothing. Every eviction pulses done.
- R10: A token message for a line with no open miss is returned to home as a bounce (type 8) carrying the same count and owner flag, and it is not added to the line.
- R11: No line ever counts more than the total, and any line with write permission holds exactly the total. A read snoop that takes a token away clears write permission.
- R12: While an output message is valid and not accepted, all of its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coreValid | input | 1 | Core operation present |
| coreOp | input | 2 | 0 read, 1 write, 2 evict |
| coreLine | input | LINE_W | Line the core operation targets |
| coreReady | output | 1 | Core operation accepted this cycle when valid |
| coreDone | output | 1 | One-cycle pulse when a core operation completes |
| inValid | input | 1 | Network message present |
| inReady | output | 1 | Network message accepted this cycle when valid |
| inType | input | 3 | 0..3 snoops, 4 tokens with data, 5 tokens only |
| inLine | input | LINE_W | Line of the network message |
| inRequestor | input | ID_W | Core that started the snooped transaction |
| inTokens | input | TOK_W | Tokens carried by a token message |
| inOwner | input | 1 | Owner token carried by a token message |
| outValid | output | 1 | Output message present |
| outReady | input | 1 | Network takes the output message |
| outType | output | 4 | Output message kind (0..8 as in the requirements) |
| outToHome | output | 1 | 1 sends to the home directory, 0 to outDest |
| outDest | output | ID_W | Requesting core for direct messages, 0 for home |
| outLine | output | LINE_W | Line of the output message |
| outTokens | output | TOK_W | Tokens carried or reported |
| outOwner | output | 1 | Owner token carried or reported |

## Verification
Snoops are tried on lines the agent holds in four situations: owner with many tokens, owner with a single token, non-owner holder, and no tokens. This separates answering with data from answering with a report, and answering from staying silent. Token arrivals come split across several messages, with and without data, for read misses and write misses. This tells a miss that ends on any token from one that needs data or the full total. Other token arrivals name a line with no open miss, to tell bouncing from absorbing. After each snoop or eviction, a following core operation shows whether the line still holds tokens or write permission. One two-message answer is held back by the network, to show the fields stay put and the order survives.

// File: rtl/tca_pkg.sv
package tca_pkg;

  typedef enum logic [2:0] {
    IN_RECON_RD = 3'd0,
    IN_RECON_WR = 3'd1,
    IN_FWD_RD   = 3'd2,
    IN_FWD_WR   = 3'd3,
    IN_TOK_DATA = 3'd4,
    IN_TOK_ONLY = 3'd5
  } inKind_e;

  typedef enum logic [3:0] {
    OUT_REQ_RD   = 4'd0,
    OUT_REQ_WR   = 4'd1,
    OUT_DATA     = 4'd2,
    OUT_TOK      = 4'd3,
    OUT_REPORT   = 4'd4,
    OUT_UNBLOCK  = 4'd5,
    OUT_PUT_DATA = 4'd6,
    OUT_PUT_TOK  = 4'd7,
    OUT_BOUNCE   = 4'd8
  } outKind_e;

  localparam logic [1:0] CORE_RD    = 2'd0;
  localparam logic [1:0] CORE_WR    = 2'd1;
  localparam logic [1:0] CORE_EVICT = 2'd2;

  // which message the datapath assembles into the output slot
  typedef enum logic [2:0] {
    MK_REQ, MK_GIVE_ONE, MK_REPORT, MK_GIVE_ALL, MK_UNBLOCK, MK_PUT, MK_BOUNCE
  } msgSel_e;

  typedef struct packed {
    logic    useCore;     // table lookup follows the core line
    logic    loadOut;     // load the output slot
    msgSel_e outSel;
    logic    loadPend;    // queue a report behind the output slot
    logic    tabAdd;      // absorb incoming tokens
    logic    tabGiveOne;  // hand one token away
    logic    tabClear;    // line loses everything
    logic    setWritable;
    logic    startMiss;
    logic    endMiss;
  } ctrlStrobe_t;

endpackage

// File: rtl/tca_datapath.sv
module tca_datapath
  import tca_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int TOK_W     = $clog2(NUM_CORES + 1),
  parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  parameter int ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  ctrlStrobe_t                      strobe,
  input  logic [LINE_W-1:0]                inLine,
  input  logic [ID_W-1:0]                  inRequestor,
  input  logic [TOK_W-1:0]                 inTokens,
  input  logic                             inOwner,
  input  logic [LINE_W-1:0]                coreLine,
  input  logic                             coreWrite,
  input  logic                             outReady,
  output logic [TOK_W-1:0]                 curTok,
  output logic                             curOwner,
  output logic [TOK_W:0]                   sumTok,
  output logic                             missActive,
  output logic [LINE_W-1:0]                missLine,
  output logic                             missWrite,
  output logic                             slotBusy,
  output logic                             outValid,
  output logic [3:0]                       outType,
  output logic                             outToHome,
  output logic [ID_W-1:0]                  outDest,
  output logic [LINE_W-1:0]                outLine,
  output logic [TOK_W-1:0]                 outTokens,
  output logic                             outOwner,
  output logic [NUM_LINES-1:0][TOK_W-1:0]  tokView,
  output logic [NUM_LINES-1:0]             wrView
);

  logic [NUM_LINES-1:0][TOK_W-1:0] tokQ;
  logic [NUM_LINES-1:0]            ownQ;
  logic [NUM_LINES-1:0]            wrQ;
  logic [LINE_W-1:0]               selLine;

  assign selLine  = strobe.useCore ? coreLine : inLine;
  assign curTok   = tokQ[selLine];
  assign curOwner = ownQ[selLine];
  assign sumTok   = {1'b0, curTok} + {1'b0, inTokens};
  assign tokView  = tokQ;
  assign wrView   = wrQ;

  // line table
  always_ff @(posedge clk) begin
    if (rst) begin
      tokQ <= '0;
      ownQ <= '0;
      wrQ  <= '0;
    end else begin
      if (strobe.tabClear) begin
        tokQ[selLine] <= '0;
        ownQ[selLine] <= 1'b0;
        wrQ[selLine]  <= 1'b0;
      end else if (strobe.tabGiveOne) begin
        tokQ[selLine] <= curTok - TOK_W'(1);
        ownQ[selLine] <= curOwner && (curTok > TOK_W'(1));
        wrQ[selLine]  <= 1'b0;
      end else if (strobe.tabAdd) begin
        tokQ[selLine] <= sumTok[TOK_W-1:0];
        ownQ[selLine] <= curOwner | inOwner;
      end
      if (strobe.setWritable) wrQ[selLine] <= 1'b1;
    end
  end

  // message assembly
  outKind_e          msgType;
  logic              msgHome;
  logic [ID_W-1:0]   msgDest;
  logic [TOK_W-1:0]  msgTok;
  logic              msgOwn;
  logic [TOK_W-1:0]  repTok;
  logic              repOwn;

  assign repTok = curOwner ? curTok - TOK_W'(1) : curTok;
  assign repOwn = curOwner && (curTok > TOK_W'(1));

  always_comb begin
    msgType = OUT_REPORT;
    msgHome = 1'b1;
    msgDest = '0;
    msgTok  = '0;
    msgOwn  = 1'b0;
    case (strobe.outSel)
      MK_REQ:      msgType = coreWrite ? OUT_REQ_WR : OUT_REQ_RD;
      MK_GIVE_ONE: begin
        msgType = OUT_DATA;
        msgHome = 1'b0;
        msgDest = inRequestor;
        msgTok  = TOK_W'(1);
        msgOwn  = (curTok == TOK_W'(1));
      end
      MK_REPORT: begin
        msgTok = repTok;
        msgOwn = repOwn;
      end
      MK_GIVE_ALL: begin
        msgType = curOwner ? OUT_DATA : OUT_TOK;
        msgHome = 1'b0;
        msgDest = inRequestor;
        msgTok  = curTok;
        msgOwn  = curOwner;
      end
      MK_UNBLOCK: begin
        msgType = OUT_UNBLOCK;
        msgTok  = sumTok[TOK_W-1:0];
        msgOwn  = curOwner | inOwner;
      end
      MK_PUT: begin
        msgType = curOwner ? OUT_PUT_DATA : OUT_PUT_TOK;
        msgTok  = curTok;
        msgOwn  = curOwner;
      end
      MK_BOUNCE: begin
        msgType = OUT_BOUNCE;
        msgTok  = inTokens;
        msgOwn  = inOwner;
      end
      default: ;
    endcase
  end

  // output slot plus one queued report
  logic              pendValid;
  logic [LINE_W-1:0] pendLine;
  logic [TOK_W-1:0]  pendTok;
  logic              pendOwn;

  assign slotBusy = outValid | pendValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      pendValid <= 1'b0;
      outType   <= '0;
      outToHome <= 1'b0;
      outDest   <= '0;
      outLine   <= '0;
      outTokens <= '0;
      outOwner  <= 1'b0;
      pendLine  <= '0;
      pendTok   <= '0;
      pendOwn   <= 1'b0;
    end else if (strobe.loadOut) begin
      outValid  <= 1'b1;
      outType   <= msgType;
      outToHome <= msgHome;
      outDest   <= msgDest;
      outLine   <= selLine;
      outTokens <= msgTok;
      outOwner  <= msgOwn;
      if (strobe.loadPend) begin
        pendValid <= 1'b1;
        pendLine  <= selLine;
        pendTok   <= repTok;
        pendOwn   <= repOwn;
      end
    end else if (outValid && outReady) begin
      if (pendValid) begin
        pendValid <= 1'b0;
        outType   <= OUT_REPORT;
        outToHome <= 1'b1;
        outDest   <= '0;
        outLine   <= pendLine;
        outTokens <= pendTok;
        outOwner  <= pendOwn;
      end else begin
        outValid <= 1'b0;
      end
    end
  end

  // the single open miss
  always_ff @(posedge clk) begin
    if (rst) begin
      missActive <= 1'b0;
      missLine   <= '0;
      missWrite  <= 1'b0;
    end else if (strobe.startMiss) begin
      missActive <= 1'b1;
      missLine   <= coreLine;
      missWrite  <= coreWrite;
    end else if (strobe.endMiss) begin
      missActive <= 1'b0;
    end
  end

endmodule

// File: rtl/tca_ctrl.sv
module tca_ctrl
  import tca_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int TOK_W     = $clog2(NUM_CORES + 1),
  parameter int LINE_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [2:0]        inType,
  input  logic [LINE_W-1:0] inLine,
  input  logic              coreValid,
  input  logic [1:0]        coreOp,
  input  logic [TOK_W-1:0]  curTok,
  input  logic              curOwner,
  input  logic [TOK_W:0]    sumTok,
  input  logic              missActive,
  input  logic [LINE_W-1:0] missLine,
  input  logic              missWrite,
  input  logic              slotBusy,
  output logic              inReady,
  output logic              coreReady,
  output logic              coreDone,
  output ctrlStrobe_t       strobe
);

  localparam logic [TOK_W-1:0] FULL_TOK = TOK_W'(NUM_CORES);
  localparam logic [TOK_W:0]   FULL_SUM = (TOK_W + 1)'(NUM_CORES);

  logic inFire, coreFire, doneNext, isReadSnoop, finish;

  assign inReady   = !slotBusy;
  assign coreReady = !slotBusy && !inValid && !missActive;
  assign inFire    = inValid && inReady;
  assign coreFire  = coreValid && coreReady;

  assign isReadSnoop = (inType == IN_RECON_RD) || (inType == IN_FWD_RD);
  assign finish = missWrite ? (sumTok == FULL_SUM)
                            : ((inType == IN_TOK_DATA) && (sumTok != '0));

  always_comb begin
    strobe         = '0;
    strobe.outSel  = MK_REQ;
    strobe.useCore = !inValid;
    doneNext       = 1'b0;
    if (inFire) begin
      if (inType <= IN_FWD_WR) begin
        if (curTok != '0) begin
          strobe.loadOut = 1'b1;
          if (!isReadSnoop) begin
            strobe.outSel   = MK_GIVE_ALL;
            strobe.tabClear = 1'b1;
          end else if (curOwner) begin
            strobe.outSel     = MK_GIVE_ONE;
            strobe.loadPend   = 1'b1;
            strobe.tabGiveOne = 1'b1;
          end else begin
            strobe.outSel = MK_REPORT;
          end
        end
      end else if (inType <= IN_TOK_ONLY) begin
        if (missActive && (missLine == inLine)) begin
          strobe.tabAdd = 1'b1;
          if (finish) begin
            strobe.loadOut     = 1'b1;
            strobe.outSel      = MK_UNBLOCK;
            strobe.endMiss     = 1'b1;
            strobe.setWritable = missWrite;
            doneNext           = 1'b1;
          end
        end else begin
          strobe.loadOut = 1'b1;
          strobe.outSel  = MK_BOUNCE;
        end
      end
    end else if (coreFire) begin
      case (coreOp)
        CORE_RD: begin
          if (curTok != '0) doneNext = 1'b1;
          else begin
            strobe.loadOut   = 1'b1;
            strobe.startMiss = 1'b1;
          end
        end
        CORE_WR: begin
          if (curTok == FULL_TOK) begin
            doneNext           = 1'b1;
            strobe.setWritable = 1'b1;
          end else begin
            strobe.loadOut   = 1'b1;
            strobe.startMiss = 1'b1;
          end
        end
        CORE_EVICT: begin
          doneNext = 1'b1;
          if (curTok != '0) begin
            strobe.loadOut  = 1'b1;
            strobe.outSel   = MK_PUT;
            strobe.tabClear = 1'b1;
          end
        end
        default: doneNext = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) coreDone <= 1'b0;
    else     coreDone <= doneNext;
  end

endmodule

// File: rtl/tca_agent.sv
module tca_agent
  import tca_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int TOK_W     = $clog2(NUM_CORES + 1),
  parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  parameter int ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coreValid,
  input  logic [1:0]        coreOp,
  input  logic [LINE_W-1:0] coreLine,
  output logic              coreReady,
  output logic              coreDone,
  input  logic              inValid,
  output logic              inReady,
  input  logic [2:0]        inType,
  input  logic [LINE_W-1:0] inLine,
  input  logic [ID_W-1:0]   inRequestor,
  input  logic [TOK_W-1:0]  inTokens,
  input  logic              inOwner,
  output logic              outValid,
  input  logic              outReady,
  output logic [3:0]        outType,
  output logic              outToHome,
  output logic [ID_W-1:0]   outDest,
  output logic [LINE_W-1:0] outLine,
  output logic [TOK_W-1:0]  outTokens,
  output logic              outOwner
);

  ctrlStrobe_t                     strobe;
  logic [TOK_W-1:0]                curTok;
  logic                            curOwner;
  logic [TOK_W:0]                  sumTok;
  logic                            missActive;
  logic [LINE_W-1:0]               missLine;
  logic                            missWrite;
  logic                            slotBusy;
  logic [NUM_LINES-1:0][TOK_W-1:0] tokView;
  logic [NUM_LINES-1:0]            wrView;
  logic                            coreWrite;

  assign coreWrite = (coreOp == CORE_WR);

  tca_ctrl #(.NUM_CORES(NUM_CORES), .TOK_W(TOK_W), .LINE_W(LINE_W)) u_ctrl (
    .clk, .rst, .inValid, .inType, .inLine, .coreValid, .coreOp,
    .curTok, .curOwner, .sumTok, .missActive, .missLine, .missWrite,
    .slotBusy, .inReady, .coreReady, .coreDone, .strobe
  );

  tca_datapath #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES), .TOK_W(TOK_W),
                 .LINE_W(LINE_W), .ID_W(ID_W)) u_dp (
    .clk, .rst, .strobe, .inLine, .inRequestor, .inTokens, .inOwner,
    .coreLine, .coreWrite, .outReady, .curTok, .curOwner, .sumTok,
    .missActive, .missLine, .missWrite, .slotBusy, .outValid, .outType,
    .outToHome, .outDest, .outLine, .outTokens, .outOwner, .tokView, .wrView
  );

endmodule

// File: rtl/tca_checker.sv
module tca_checker #(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int TOK_W     = $clog2(NUM_CORES + 1),
  parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  parameter int ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            coreValid,
  input logic [1:0]                      coreOp,
  input logic [LINE_W-1:0]               coreLine,
  input logic                            coreReady,
  input logic                            coreDone,
  input logic                            inValid,
  input logic                            inReady,
  input logic [2:0]                      inType,
  input logic [LINE_W-1:0]               inLine,
  input logic                            outValid,
  input logic                            outReady,
  input logic [3:0]                      outType,
  input logic                            outToHome,
  input logic [LINE_W-1:0]               outLine,
  input logic [TOK_W-1:0]                outTokens,
  input logic                            outOwner,
  input logic [NUM_LINES-1:0][TOK_W-1:0] tokView,
  input logic [NUM_LINES-1:0]            wrView
);

  localparam logic [TOK_W-1:0] FULL_TOK = TOK_W'(NUM_CORES);

  logic inFire, coreFire;
  assign inFire   = inValid && inReady;
  assign coreFire = coreValid && coreReady;

  // R11 invariants on every line
  always @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        a_r11_tok_bound: assert (tokView[i] <= FULL_TOK)
          else $error("line %0d holds %0d tokens", i, tokView[i]);
        a_r11_write_full: assert (!wrView[i] || tokView[i] == FULL_TOK)
          else $error("line %0d writable with %0d tokens", i, tokView[i]);
      end
    end
  end

  a_r2_zero_silent: assert property (@(posedge clk) disable iff (rst)
    (inFire && inType <= 3'd3 && tokView[inLine] == '0) |=> !outValid);

  a_r5_write_snoop_empties: assert property (@(posedge clk) disable iff (rst)
    (inFire && (inType == 3'd1 || inType == 3'd3)) |=> tokView[$past(inLine)] == '0);

  a_r8_hit_silent: assert property (@(posedge clk) disable iff (rst)
    (coreFire && coreOp == 2'd1 && tokView[coreLine] == FULL_TOK) |=> (coreDone && !outValid));

  a_r9_put_data_owned: assert property (@(posedge clk) disable iff (rst)
    (outValid && outType == 4'd6) |-> (outOwner && outToHome));

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outType) && $stable(outLine)
                                 && $stable(outTokens) && $stable(outOwner)));

endmodule

bind tca_agent tca_checker #(
  .NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES), .TOK_W(TOK_W),
  .LINE_W(LINE_W), .ID_W(ID_W)
) u_tca_checker (.*);

// File: tb/tca_agent_bench.sv
module tca_agent_bench;

  localparam int N = 4, L = 8, TW = 3, LW = 3, IW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic coreValid = 0, coreReady, coreDone;
  logic [1:0] coreOp = 0;
  logic [LW-1:0] coreLine = 0;
  logic inValid = 0, inReady, inOwner = 0;
  logic [2:0] inType = 0;
  logic [LW-1:0] inLine = 0;
  logic [IW-1:0] inRequestor = 0;
  logic [TW-1:0] inTokens = 0;
  logic outValid, outReady = 1, outToHome, outOwner;
  logic [3:0] outType;
  logic [IW-1:0] outDest;
  logic [LW-1:0] outLine;
  logic [TW-1:0] outTokens;

  always #10 clk = ~clk;  // 50 MHz

  tca_agent #(.NUM_CORES(N), .NUM_LINES(L)) u_tca_agent (.*);

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [13:0] expQ[$];
  string tagQ[$];

  function automatic logic [13:0] msg(input logic [3:0] t, input logic h,
      input logic [IW-1:0] d, input logic [LW-1:0] ln, input logic [TW-1:0] tk, input logic o);
    return {t, h, d, ln, tk, o};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectMsg(input logic [13:0] m, input string tag);
    expQ.push_back(m);
    tagQ.push_back(tag);
  endtask

  // monitor: pops the scoreboard on every accepted output
  always @(negedge clk) begin
    if (!rst && outValid && outReady) begin
      logic [13:0] got;
      got = msg(outType, outToHome, outDest, outLine, outTokens, outOwner);
      if (expQ.size() == 0) check(0, "unexpected message", int'(got), 0);
      else begin
        logic [13:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(got == e, t, int'(got), int'(e));
      end
    end
  end

  task automatic netSend(input logic [2:0] t, input logic [LW-1:0] ln, input logic [IW-1:0] rq,
      input logic [TW-1:0] tk, input logic o, input bit expDone, input string tag);
    inType = t; inLine = ln; inRequestor = rq; inTokens = tk; inOwner = o; inValid = 1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 0;
    check(coreDone == expDone, tag, coreDone, expDone);
    repeat (3) @(negedge clk);
  endtask

  task automatic coreDo(input logic [1:0] op, input logic [LW-1:0] ln, input bit expDone,
      input string tag);
    coreOp = op; coreLine = ln; coreValid = 1;
    while (!coreReady) @(negedge clk);
    @(negedge clk);
    coreValid = 0;
    check(coreDone == expDone, tag, coreDone, expDone);
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(outValid == 0, "R1 outValid", outValid, 0);
    check(coreReady == 1 && inReady == 1, "R1 ready", {coreReady, inReady}, 3);

    // R2 zero-token snoops stay silent; R1 line empty so read misses
    netSend(3'd0, 3'd2, 2'd1, 0, 0, 0, "R2 recon read empty");
    netSend(3'd3, 3'd2, 2'd1, 0, 0, 0, "R2 fwd write empty");
    expectMsg(msg(4'd0, 1, 0, 3'd2, 0, 0), "R1 R6 read request");
    coreDo(2'd0, 3'd2, 0, "R6 miss not done");
    expectMsg(msg(4'd5, 1, 0, 3'd2, 1, 0), "R6 unblock");
    netSend(3'd4, 3'd2, 0, 1, 0, 1, "R6 read done");

    // R7 write miss collecting in three pieces
    expectMsg(msg(4'd1, 1, 0, 3'd3, 0, 0), "R7 write request");
    coreDo(2'd1, 3'd3, 0, "R7 miss open");
    netSend(3'd5, 3'd3, 0, 1, 0, 0, "R7 partial 1");
    netSend(3'd4, 3'd3, 0, 2, 1, 0, "R7 partial 3");
    expectMsg(msg(4'd5, 1, 0, 3'd3, 4, 1), "R7 unblock full");
    netSend(3'd5, 3'd3, 0, 1, 0, 1, "R7 write done");

    // R8 silent hits
    coreDo(2'd1, 3'd3, 1, "R8 write hit");
    coreDo(2'd0, 3'd2, 1, "R8 read hit");

    // R3 owner read snoop under backpressure (R12)
    outReady = 0;
    expectMsg(msg(4'd2, 0, 2'd2, 3'd3, 1, 0), "R3 data one token");
    expectMsg(msg(4'd4, 1, 0, 3'd3, 3, 1), "R3 report remaining");
    netSend(3'd0, 3'd3, 2'd2, 0, 0, 0, "R3 snoop accepted");
    check(outValid && outType == 4'd2 && outTokens == 1, "R12 held", outType, 2);
    repeat (2) @(negedge clk);
    check(outValid && outType == 4'd2 && outDest == 2'd2, "R12 still held", outType, 2);
    outReady = 1;
    repeat (4) @(negedge clk);

    // R11 write permission lost after giving a token
    expectMsg(msg(4'd1, 1, 0, 3'd3, 0, 0), "R11 write needs request");
    coreDo(2'd1, 3'd3, 0, "R11 no silent write");
    expectMsg(msg(4'd5, 1, 0, 3'd3, 4, 1), "R7 upgrade unblock");
    netSend(3'd5, 3'd3, 0, 1, 0, 1, "R7 upgrade done");

    // R4 non-owner read snoops
    expectMsg(msg(4'd4, 1, 0, 3'd2, 1, 0), "R4 report recon");
    netSend(3'd0, 3'd2, 2'd3, 0, 0, 0, "R4 recon");
    expectMsg(msg(4'd4, 1, 0, 3'd2, 1, 0), "R4 report fwd");
    netSend(3'd2, 3'd2, 2'd1, 0, 0, 0, "R4 fwd");

    // R5 forwarded write at owner
    expectMsg(msg(4'd2, 0, 2'd1, 3'd3, 4, 1), "R5 all tokens to requestor");
    netSend(3'd3, 3'd3, 2'd1, 0, 0, 0, "R5 fwd write");
    expectMsg(msg(4'd0, 1, 0, 3'd3, 0, 0), "R5 line emptied");
    coreDo(2'd0, 3'd3, 0, "R5 read misses");
    expectMsg(msg(4'd5, 1, 0, 3'd3, 1, 1), "R6 unblock owner");
    netSend(3'd4, 3'd3, 0, 1, 1, 1, "R6 done owner");

    // R3 single-token owner passes ownership
    expectMsg(msg(4'd2, 0, 2'd0, 3'd3, 1, 1), "R3 ownership passes");
    expectMsg(msg(4'd4, 1, 0, 3'd3, 0, 0), "R3 report zero");
    netSend(3'd0, 3'd3, 2'd0, 0, 0, 0, "R3 single token");
    netSend(3'd1, 3'd3, 2'd0, 0, 0, 0, "R2 now empty");

    // R5 write reconstruction at non-owner
    expectMsg(msg(4'd3, 0, 2'd0, 3'd2, 1, 0), "R5 tokens only");
    netSend(3'd1, 3'd2, 2'd0, 0, 0, 0, "R5 recon write");

    // R9 evictions
    expectMsg(msg(4'd1, 1, 0, 3'd5, 0, 0), "R7 request line5");
    coreDo(2'd1, 3'd5, 0, "R7 open line5");
    expectMsg(msg(4'd5, 1, 0, 3'd5, 4, 1), "R7 unblock line5");
    netSend(3'd4, 3'd5, 0, 4, 1, 1, "R7 done line5");
    expectMsg(msg(4'd6, 1, 0, 3'd5, 4, 1), "R9 put data");
    coreDo(2'd2, 3'd5, 1, "R9 evict owned");
    expectMsg(msg(4'd0, 1, 0, 3'd6, 0, 0), "R6 request line6");
    coreDo(2'd0, 3'd6, 0, "R6 open line6");
    expectMsg(msg(4'd5, 1, 0, 3'd6, 2, 0), "R6 unblock line6");
    netSend(3'd4, 3'd6, 0, 2, 0, 1, "R6 done line6");
    expectMsg(msg(4'd7, 1, 0, 3'd6, 2, 0), "R9 put tokens");
    coreDo(2'd2, 3'd6, 1, "R9 evict shared");
    coreDo(2'd2, 3'd6, 1, "R9 evict empty silent");
    expectMsg(msg(4'd0, 1, 0, 3'd5, 0, 0), "R9 line5 cleared");
    coreDo(2'd0, 3'd5, 0, "R9 read after evict");
    expectMsg(msg(4'd5, 1, 0, 3'd5, 1, 0), "R6 unblock line5");
    netSend(3'd4, 3'd5, 0, 1, 0, 1, "R6 done line5");

    // R10 unrequested tokens bounce
    expectMsg(msg(4'd8, 1, 0, 3'd7, 2, 1), "R10 bounce no miss");
    netSend(3'd4, 3'd7, 0, 2, 1, 0, "R10 bounce");
    expectMsg(msg(4'd0, 1, 0, 3'd7, 0, 0), "R10 not absorbed");
    coreDo(2'd0, 3'd7, 0, "R10 read misses");
    check(coreReady == 0, "R6 core busy during miss", coreReady, 0);
    expectMsg(msg(4'd8, 1, 0, 3'd4, 1, 0), "R10 bounce other line");
    netSend(3'd5, 3'd4, 0, 1, 0, 0, "R10 other line");
    netSend(3'd5, 3'd7, 0, 1, 0, 0, "R6 tokens without data wait");
    expectMsg(msg(4'd5, 1, 0, 3'd7, 2, 1), "R6 unblock after data");
    netSend(3'd4, 3'd7, 0, 1, 1, 1, "R6 done with data");

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule